// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps the running wall-clock time for a network port's timestamp unit. It advances once per clock by a programmable step that has a whole-nanosecond part and a 24-bit binary fraction of a nanosecond. The fraction builds up in a hidden accumulator. When that accumulator overflows, the tick adds one extra nanosecond. The nanoseconds field rolls over at one second and carries into a 48-bit seconds count.

Software drives the block through a single-cycle write strobe with a small address. It can load the nanoseconds field directly. It can load seconds through a high/low pair, where the high part waits in a staging register until the low part is written. The step is also loaded as a pair: the fraction is held back until the whole-nanosecond part is written, and then both take effect together. A signed offset of less than one second can be applied once. It lands on the tick after the write and borrows from or carries into seconds. Seconds and nanoseconds are always visible on the output ports. They are not latched as a pair.

Top module: `tod_counter`

## Requirements
- R1: After a synchronous active-low reset, seconds, nanoseconds, the step and all staged values are zero. With a zero step and no writes, the time holds its value.
- R2: On each clock, the nanoseconds field grows by the whole-nanosecond step (address 4, bits [7:0]) plus one more whenever the fraction accumulator overflows.
- R3: The 24-bit fraction accumulates modulo 2^24, and each overflow adds exactly one nanosecond. A fraction of 0x800000 adds one extra nanosecond on every second tick.
- R4: In the fraction write (address 3), data bits [15:0] become fraction bits [23:8] and data bits [31:24] become fraction bits [7:0]. Data bits [23:16] are ignored.
- R5: A fraction write does not change the active step. The active step changes only on a later write to address 4, which installs the staged fraction and the new whole part together.
- R6: A write to the seconds-high register (address 1, bits [15:0]) leaves the running seconds unchanged. A write to seconds-low (address 2) loads seconds as {staged high, data[31:0]} on that edge.
- R7: A write to address 0 loads nanoseconds with data[29:0] on that edge, replacing that tick's step.
- R8: When the next nanoseconds value would reach 1,000,000,000 or more, the block subtracts 1,000,000,000 from it and increments seconds by one.
- R9: An adjust write (address 5) with bit 31 clear adds data[29:0] nanoseconds (a value below 10^9), carrying into seconds on overflow.
- R10: An adjust write with bit 31 set subtracts data[29:0] nanoseconds. If the result goes below zero, the block adds 1,000,000,000 back and decrements seconds.
- R11: The adjust write edge itself advances time by the normal step only. The offset is added together with the normal step on the following edge. Only one adjust may be in flight at once.
- R12: Reset discards a staged fraction and a staged seconds-high value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timestamp-unit clock, one tick per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per register write |
| wr_addr | input | 3 | Register select: 0 ns, 1 sec-high, 2 sec-low, 3 fraction, 4 whole step, 5 adjust (6 and 7 ignored) |
| wr_data | input | 32 | Write data |
| sec_o | output | 48 | Current seconds |
| ns_o | output | 30 | Current nanoseconds, always below 10^9 |

## Verification
A corrupt fraction accumulator or a wrong fraction bit mapping shows at ns_o only slowly. An error in the lowest fraction byte needs about 65,537 ticks before it changes the nanoseconds count by one, so the bench runs that long. A staged value that leaks into the live state shows at the port on the edge after the fraction or seconds-high write, because the time then moves where it should hold still. A wrong carry or borrow path shows in sec_o on the very edge where nanoseconds crosses a second boundary, and each of these is checked at the exact boundary value.

// File: rtl/tod_pkg.sv
// Shared constants for the time-of-day counter: register addresses
// and the fixed layout widths. Assumes a 32-bit write data bus.
package tod_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 32;
    localparam int FRAC_W    = 24;   // fixed by the split fraction layout
    localparam int ADJ_SIGN  = 31;

    typedef enum logic [ADDR_W-1:0] {
        A_NS       = 3'd0,
        A_SEC_HI   = 3'd1,
        A_SEC_LO   = 3'd2,
        A_FRAC     = 3'd3,
        A_WHOLE    = 3'd4,
        A_ADJUST   = 3'd5
    } tod_addr_e;
endpackage

// File: rtl/tod_incr_regs.sv
// Step registers: holds a fraction write in a staging register and
// installs it, together with the whole-ns part, only on a whole-ns write.
// Assumes wr_frac and wr_whole are never high in the same cycle.
module tod_incr_regs
    import tod_pkg::*;
#(
    parameter int INC_NS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_frac,
    input  logic                wr_whole,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [INC_NS_W-1:0] inc_ns,
    output logic [FRAC_W-1:0]   inc_frac
);
    logic [FRAC_W-1:0] pend_frac;
    logic [FRAC_W-1:0] frac_unpacked;
    logic              bits_unused;

    // Reorder the split register layout into a contiguous fraction.
    assign frac_unpacked = {wr_data[15:0], wr_data[31:24]};
    assign bits_unused   = ^wr_data[23:16];

    // Stage the fraction; commit both parts on a whole-ns write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_frac <= '0;
            inc_frac  <= '0;
            inc_ns    <= '0;
        end else begin
            if (wr_frac)
                pend_frac <= frac_unpacked;
            if (wr_whole) begin
                inc_frac <= pend_frac;
                inc_ns   <= wr_data[INC_NS_W-1:0];
            end
        end
    end

    // R5: a staged fraction alone never alters the active step.
    a_r5_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frac && !wr_whole) |=> ($stable(inc_frac) && $stable(inc_ns)));
endmodule

// File: rtl/tod_write_stage.sv
// Write staging: keeps the seconds-high value until the low word arrives,
// and turns an adjust write into a one-cycle pending offset.
// Assumes at most one adjust write in flight.
module tod_write_stage
    import tod_pkg::*;
#(
    parameter int SEC_HI_W  = 16,
    parameter int ADJ_MAG_W = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_hi,
    input  logic                 wr_adj,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [SEC_HI_W-1:0]  hi_stage,
    output logic                 adj_valid,
    output logic                 adj_neg,
    output logic [ADJ_MAG_W-1:0] adj_mag
);
    // Capture staged seconds-high and the pending adjust.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage  <= '0;
            adj_valid <= 1'b0;
            adj_neg   <= 1'b0;
            adj_mag   <= '0;
        end else begin
            if (wr_hi)
                hi_stage <= wr_data[SEC_HI_W-1:0];
            adj_valid <= wr_adj;
            if (wr_adj) begin
                adj_neg <= wr_data[ADJ_SIGN];
                adj_mag <= wr_data[ADJ_MAG_W-1:0];
            end
        end
    end

    // R11: no second adjust while one is pending.
    a_r11_one_adjust: assert property (@(posedge clk) disable iff (!rst_n)
        adj_valid |-> !wr_adj);
    // R11: the pending offset lives for exactly one tick.
    a_r11_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        adj_valid |=> !adj_valid);
endmodule

// File: rtl/tod_time_core.sv
// Time core: fraction accumulator, nanoseconds with one-second wrap,
// signed one-shot offset, and the seconds counter with carry and borrow.
// Assumes loaded ns and offset magnitudes are below NS_PER_SEC.
module tod_time_core
    import tod_pkg::*;
#(
    parameter int NS_W       = 30,
    parameter int SEC_W      = 48,
    parameter int INC_NS_W   = 8,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INC_NS_W-1:0] inc_ns,
    input  logic [FRAC_W-1:0]   inc_frac,
    input  logic                adj_valid,
    input  logic                adj_neg,
    input  logic [NS_W-1:0]     adj_mag,
    input  logic                ld_ns,
    input  logic [NS_W-1:0]     ld_ns_val,
    input  logic                ld_sec,
    input  logic [SEC_W-1:0]    ld_sec_val,
    output logic [NS_W-1:0]     ns_q,
    output logic [SEC_W-1:0]    sec_q
);
    localparam int SW = NS_W + 4;
    localparam logic [SW-1:0] ONE_SEC = SW'(NS_PER_SEC);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic [SW-1:0]     t_step, t_adj, t_sum, t_fix;
    logic              borrow, carry;
    logic              hi_unused;

    // Fraction sum and whole step including the fraction carry.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, inc_frac};
        t_step  = SW'(inc_ns) + SW'(acc_sum[FRAC_W]);
        t_adj   = '0;
        if (adj_valid)
            t_adj = adj_neg ? (SW'(0) - SW'(adj_mag)) : SW'(adj_mag);
        t_sum   = SW'(ns_q) + t_step + t_adj;
    end

    // Fold the raw sum back into one second, noting carry or borrow.
    always_comb begin
        borrow = t_sum[SW-1];
        carry  = !borrow && (t_sum >= ONE_SEC);
        if (borrow)
            t_fix = t_sum + ONE_SEC;
        else if (carry)
            t_fix = t_sum - ONE_SEC;
        else
            t_fix = t_sum;
    end

    assign hi_unused = ^t_fix[SW-1:NS_W];

    // Advance the time; software loads take priority per field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ns_q  <= '0;
            sec_q <= '0;
        end else begin
            acc_q <= acc_sum[FRAC_W-1:0];
            ns_q  <= ld_ns ? ld_ns_val : t_fix[NS_W-1:0];
            if (ld_sec)
                sec_q <= ld_sec_val;
            else if (carry)
                sec_q <= sec_q + SEC_W'(1);
            else if (borrow)
                sec_q <= sec_q - SEC_W'(1);
        end
    end

    // R8: nanoseconds stay inside one second.
    a_r8_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
        ns_q < NS_W'(NS_PER_SEC));
    // R7: a nanoseconds load lands on that edge.
    a_r7_ns_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ns |=> ns_q == $past(ld_ns_val));
    // R6: the seconds low write installs the full seconds value.
    a_r6_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_sec |=> sec_q == $past(ld_sec_val));
    // R1: zero step and no activity keeps time frozen.
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_ns == '0 && inc_frac == '0 && !adj_valid && !ld_ns && !ld_sec)
        |=> ($stable(ns_q) && $stable(sec_q)));
endmodule

// File: rtl/tod_counter.sv
// Top of the time-of-day counter: decodes register writes and wires the
// step registers, write staging and time core together.
// Assumes one write per cycle and legal values (ns and offsets < 1 s).
module tod_counter
    import tod_pkg::*;
#(
    parameter int NS_W       = 30,
    parameter int SEC_HI_W   = 16,
    parameter int SEC_LO_W   = 32,
    parameter int INC_NS_W   = 8,
    parameter int NS_PER_SEC = 1000000000,
    localparam int SEC_W     = SEC_HI_W + SEC_LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SEC_W-1:0]  sec_o,
    output logic [NS_W-1:0]   ns_o
);
    logic wr_ns, wr_hi, wr_lo, wr_frac, wr_whole, wr_adj;
    logic [INC_NS_W-1:0] inc_ns;
    logic [FRAC_W-1:0]   inc_frac;
    logic [SEC_HI_W-1:0] hi_stage;
    logic                adj_valid, adj_neg;
    logic [NS_W-1:0]     adj_mag;
    logic                data_unused;

    // Address decode of the single write strobe.
    always_comb begin
        wr_ns    = wr_en && (wr_addr == A_NS);
        wr_hi    = wr_en && (wr_addr == A_SEC_HI);
        wr_lo    = wr_en && (wr_addr == A_SEC_LO);
        wr_frac  = wr_en && (wr_addr == A_FRAC);
        wr_whole = wr_en && (wr_addr == A_WHOLE);
        wr_adj   = wr_en && (wr_addr == A_ADJUST);
    end

    assign data_unused = wr_data[ADJ_SIGN-1];

    tod_incr_regs #(.INC_NS_W(INC_NS_W)) u_incr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_frac  (wr_frac),
        .wr_whole (wr_whole),
        .wr_data  (wr_data),
        .inc_ns   (inc_ns),
        .inc_frac (inc_frac)
    );

    tod_write_stage #(.SEC_HI_W(SEC_HI_W), .ADJ_MAG_W(NS_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hi     (wr_hi),
        .wr_adj    (wr_adj),
        .wr_data   (wr_data),
        .hi_stage  (hi_stage),
        .adj_valid (adj_valid),
        .adj_neg   (adj_neg),
        .adj_mag   (adj_mag)
    );

    tod_time_core #(
        .NS_W       (NS_W),
        .SEC_W      (SEC_W),
        .INC_NS_W   (INC_NS_W),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_ns     (inc_ns),
        .inc_frac   (inc_frac),
        .adj_valid  (adj_valid),
        .adj_neg    (adj_neg),
        .adj_mag    (adj_mag),
        .ld_ns      (wr_ns),
        .ld_ns_val  (wr_data[NS_W-1:0]),
        .ld_sec     (wr_lo),
        .ld_sec_val ({hi_stage, wr_data[SEC_LO_W-1:0]}),
        .ns_q       (ns_o),
        .sec_q      (sec_o)
    );
endmodule

// File: tb/tod_counter_bench.sv
`timescale 1ns/1ps
module tod_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [47:0] sec_o;
    logic [29:0] ns_o;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tod_counter u_tod_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sec_o(sec_o), .ns_o(ns_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    // R1: reset state and hold with zero step.
    task automatic t_reset_hold();
        do_reset();
        check("R1", "ns after reset", 64'(ns_o), 0);
        check("R1", "sec after reset", 64'(sec_o), 0);
        tick(20);
        check("R1", "ns held", 64'(ns_o), 0);
    endtask

    // R2: whole step per tick.
    task automatic t_whole_step();
        do_reset();
        wr(3'd4, 32'd7);
        check("R2", "ns at commit", 64'(ns_o), 0);
        tick(5);
        check("R2", "ns after 5 ticks", 64'(ns_o), 35);
    endtask

    // R5 staging then R3 half-fraction carry.
    task automatic t_fraction();
        do_reset();
        wr(3'd3, 32'h0000_8000);
        tick(10);
        check("R5", "ns with only fraction staged", 64'(ns_o), 0);
        wr(3'd4, 32'd3);
        tick(3);
        check("R3", "ns after 3 ticks", 64'(ns_o), 10);
        tick(1);
        check("R3", "ns after 4 ticks", 64'(ns_o), 14);
    endtask

    // R4: low fraction byte mapping and ignored middle byte.
    task automatic t_frac_layout();
        do_reset();
        wr(3'd3, 32'hFFAB_FFFF);
        wr(3'd4, 32'd0);
        check("R4", "ns at commit", 64'(ns_o), 0);
        tick(65537);
        check("R4", "ns after 65537 ticks", 64'(ns_o), 65536);
    endtask

    // R6, R7, R9, R10, R11, R8 in one timed sequence with step 10.
    task automatic t_load_adjust();
        do_reset();
        wr(3'd4, 32'd10);
        wr(3'd0, 32'd999_999_900);
        check("R7", "ns load", 64'(ns_o), 999_999_900);
        wr(3'd1, 32'h0000_0001);
        check("R6", "sec unchanged by high write", 64'(sec_o), 0);
        wr(3'd2, 32'd5);
        check("R6", "sec after low write", 64'(sec_o), 48'h1_0000_0005);
        check("R6", "ns across seconds load", 64'(ns_o), 999_999_920);
        wr(3'd5, 32'd100);
        check("R11", "offset not yet applied", 64'(ns_o), 999_999_930);
        tick(1);
        check("R9", "ns after positive offset", 64'(ns_o), 40);
        check("R9", "sec carry", 64'(sec_o), 48'h1_0000_0006);
        wr(3'd5, 32'h8000_0000 | 32'd200);
        check("R11", "ns on negative write edge", 64'(ns_o), 50);
        tick(1);
        check("R10", "ns after negative offset", 64'(ns_o), 999_999_860);
        check("R10", "sec borrow", 64'(sec_o), 48'h1_0000_0005);
        tick(14);
        check("R8", "ns wrap at exact second", 64'(ns_o), 0);
        check("R8", "sec after wrap", 64'(sec_o), 48'h1_0000_0006);
    endtask

    // R12: reset drops staged fraction and staged seconds-high.
    task automatic t_reset_staged();
        do_reset();
        wr(3'd3, 32'h0000_8000);
        wr(3'd1, 32'h0000_00FF);
        do_reset();
        wr(3'd4, 32'd1);
        wr(3'd2, 32'd9);
        check("R12", "sec high cleared", 64'(sec_o), 9);
        tick(4);
        check("R12", "fraction cleared", 64'(ns_o), 5);
    endtask

    initial begin
        t_reset_hold();
        t_whole_step();
        t_fraction();
        t_frac_layout();
        t_load_adjust();
        t_reset_staged();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule